// File: doc/BRIEF.md
# Packet Byte FIFO with Status Flags

This block buffers packet bytes between a host register port, which moves whole bytes one at a time, and a bit-serial packet engine. There are 64 entries of 8 bits. Writes come from one of two sources, picked by the operating mode. The host port writes in transmit and standby. The engine port writes in receive. In sleep, neither port can write. All reads go through one read strobe, and the byte appears on a registered data output.

The block reports several status outputs. Empty and full are live. Overrun is sticky and is raised by a write that arrives while the FIFO is full. The level flag compares the fill count against a 6-bit threshold. A write-one strobe clears the overrun flag and flushes the FIFO at the same time. A synchronous flush input, used on mode changes, does the same.

The host also sees a second copy of the empty flag. That copy is refreshed only when chip select falls. As a result, a read that has already begun always completes, and the host checks this copy before it decides whether to start another read.

Top module: `pktbuf_top`

## Requirements
- R1: After reset, empty_o=1, host_empty_o=1, full_o=0, overrun_o=0, level_o=0 and rd_data_o=0x00.
- R2: Bytes are read out in the order they were accepted. rd_data_o shows the byte in the cycle after the clock edge that samples rd_i.
- R3: mode_i selects which port may write: 0 (standby) and 1 (transmit) accept host_wr_i, 2 (receive) accepts eng_wr_i, and 3 (sleep) accepts neither. A strobe on a port that is not selected stores nothing.
- R4: empty_o is high exactly when no byte is held. full_o is high exactly when all 64 entries are occupied.
- R5: An accepted-port write while the FIFO holds 64 bytes is discarded and sets overrun_o. overrun_o then stays high until it is cleared. This still holds if a read happens in the same cycle.
- R6: A pulse on ovr_clr_i clears overrun_o and empties the FIFO. Any read or write in that same cycle is ignored, and rd_data_o holds its value.
- R7: level_o is high exactly when the fill count is strictly greater than thresh_i, which is 6 bits wide.
- R8: A read while empty returns 0x00 and moves no pointer. A later write and read still return the written byte.
- R9: A read and a write in the same cycle, with the FIFO neither empty nor full, leave the fill count unchanged.
- R10: flush_i clears the stored data, the fill count and overrun_o. It takes priority over a read or write in the same cycle.
- R11: host_empty_o takes the value of empty_o sampled at the clock edge that sees cs_n_i go from 1 to 0. At all other edges it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Synchronous flush on mode change |
| mode_i | input | 2 | 0 standby, 1 transmit, 2 receive, 3 sleep |
| host_wr_i | input | 1 | Host byte write strobe |
| host_wdata_i | input | 8 | Host write byte |
| eng_wr_i | input | 1 | Packet engine byte write strobe |
| eng_wdata_i | input | 8 | Packet engine write byte |
| rd_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Byte read out (0x00 on an empty read) |
| cs_n_i | input | 1 | Host chip select, active low |
| ovr_clr_i | input | 1 | Write-one clear of overrun, which also flushes |
| thresh_i | input | 6 | Level threshold |
| empty_o | output | 1 | FIFO holds no byte |
| full_o | output | 1 | FIFO holds 64 bytes |
| overrun_o | output | 1 | Sticky overrun flag |
| level_o | output | 1 | Fill count above threshold |
| host_empty_o | output | 1 | Empty flag latched on chip-select fall |

## Verification
The embedded assertions check these properties on every cycle:
- the fill count stays within bounds, and empty and full are never high together;
- overrun is set when it should be and stays sticky;
- a clear or flush zeroes the count;
- a balanced read and write keeps the count steady;
- an empty read returns zero with the pointers held;
- host_empty_o does not move between chip-select falls.

Byte ordering across pointer wrap, the selection of the write port by mode, and the exact threshold boundary can only be shown by the bench scenarios. The same applies to clear and flush taking priority over same-cycle traffic, and to the host copy of empty staying low while the FIFO drains within one access. The bench shows all of these by comparing against a queue model on every clock.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

    localparam int unsigned PB_DEPTH = 64;
    localparam int unsigned PB_WIDTH = 8;

    typedef enum logic [1:0] {
        MODE_STBY  = 2'd0,
        MODE_TX    = 2'd1,
        MODE_RX    = 2'd2,
        MODE_SLEEP = 2'd3
    } op_mode_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic clear;
    } fifo_op_t;

    typedef struct packed {
        logic empty;
        logic full;
        logic level;
        logic overrun;
    } fifo_flags_t;

    function automatic logic host_may_write(op_mode_e m);
        return (m == MODE_STBY) || (m == MODE_TX);
    endfunction

    function automatic logic eng_may_write(op_mode_e m);
        return (m == MODE_RX);
    endfunction

endpackage

// File: rtl/pktbuf_ctrl.sv
module pktbuf_ctrl
    import pktbuf_pkg::*;
#(
    parameter int unsigned DEPTH = PB_DEPTH,
    localparam int unsigned CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush_i,
    input  logic          ovr_clr_i,
    input  op_mode_e      mode_i,
    input  logic          host_wr_i,
    input  logic          eng_wr_i,
    input  logic          rd_i,
    output fifo_op_t      op_o,
    output logic          sel_eng_o,
    output logic [CW-1:0] count_o,
    output logic          overrun_o
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic          want_wr;
    logic          is_full;
    logic          is_empty;
    logic          clear;
    logic [CW-1:0] count_q;
    logic          overrun_q;

    always_comb begin
        want_wr    = (host_may_write(mode_i) && host_wr_i) ||
                     (eng_may_write(mode_i) && eng_wr_i);
        sel_eng_o  = eng_may_write(mode_i);
        is_full    = (count_q == FULL_CNT);
        is_empty   = (count_q == '0);
        clear      = flush_i || ovr_clr_i;
        op_o.clear = clear;
        op_o.push  = want_wr && !is_full && !clear;
        op_o.pop   = rd_i && !is_empty && !clear;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_q <= '0;
        end else begin
            unique case ({op_o.push, op_o.pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            overrun_q <= 1'b0;
        end else if (want_wr && is_full) begin
            overrun_q <= 1'b1;
        end
    end

    assign count_o   = count_q;
    assign overrun_o = overrun_q;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count_q <= FULL_CNT); // R4
    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        (want_wr && is_full && !clear) |=> overrun_q); // R5
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun_q && !clear) |=> overrun_q); // R5
    AST_RW_BALANCE: assert property (@(posedge clk) disable iff (rst)
        (op_o.push && op_o.pop) |=> (count_q == $past(count_q))); // R9
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count_q == '0 && !overrun_q)); // R10

endmodule

// File: rtl/pktbuf_mem.sv
module pktbuf_mem
    import pktbuf_pkg::*;
#(
    parameter int unsigned DEPTH = PB_DEPTH,
    parameter int unsigned WIDTH = PB_WIDTH,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  fifo_op_t         op_i,
    input  logic             rd_req_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rd_data_o
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] store_q [DEPTH];
    logic [AW-1:0]    wptr_q;
    logic [AW-1:0]    rptr_q;
    logic [WIDTH-1:0] rd_q;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (op_i.push) begin
            store_q[wptr_q] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || op_i.clear) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (op_i.push) wptr_q <= bump(wptr_q);
            if (op_i.pop)  rptr_q <= bump(rptr_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_req_i && !op_i.clear) begin
            rd_q <= op_i.pop ? store_q[rptr_q] : '0;
        end
    end

    assign rd_data_o = rd_q;

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_req_i && !op_i.pop && !op_i.clear) |=> (rd_q == '0)); // R8
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!op_i.push && !op_i.pop && !op_i.clear) |=> ($stable(wptr_q) && $stable(rptr_q))); // R8

endmodule

// File: rtl/pktbuf_status.sv
module pktbuf_status
    import pktbuf_pkg::*;
#(
    parameter int unsigned DEPTH = PB_DEPTH,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count_i,
    input  logic [AW-1:0] thresh_i,
    input  logic          overrun_i,
    input  logic          cs_n_i,
    output fifo_flags_t   flags_o,
    output logic          host_empty_o
);

    logic cs_n_q;
    logic host_empty_q;
    logic cs_fall;

    always_comb begin
        flags_o.empty   = (count_i == '0);
        flags_o.full    = (count_i == CW'(DEPTH));
        flags_o.level   = (count_i > {1'b0, thresh_i});
        flags_o.overrun = overrun_i;
        cs_fall         = cs_n_q && !cs_n_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_q       <= 1'b1;
            host_empty_q <= 1'b1;
        end else begin
            cs_n_q <= cs_n_i;
            if (cs_fall) host_empty_q <= flags_o.empty;
        end
    end

    assign host_empty_o = host_empty_q;

    AST_HOST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cs_fall |=> $stable(host_empty_q)); // R11
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(flags_o.empty && flags_o.full)); // R4
    AST_FULL_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        flags_o.full |-> flags_o.level); // R7

endmodule

// File: rtl/pktbuf_top.sv
module pktbuf_top
    import pktbuf_pkg::*;
#(
    parameter int unsigned DEPTH = PB_DEPTH,
    parameter int unsigned WIDTH = PB_WIDTH,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic [1:0]       mode_i,
    input  logic             host_wr_i,
    input  logic [WIDTH-1:0] host_wdata_i,
    input  logic             eng_wr_i,
    input  logic [WIDTH-1:0] eng_wdata_i,
    input  logic             rd_i,
    output logic [WIDTH-1:0] rd_data_o,
    input  logic             cs_n_i,
    input  logic             ovr_clr_i,
    input  logic [AW-1:0]    thresh_i,
    output logic             empty_o,
    output logic             full_o,
    output logic             overrun_o,
    output logic             level_o,
    output logic             host_empty_o
);

    fifo_op_t         op;
    fifo_flags_t      flags;
    logic             sel_eng;
    logic [CW-1:0]    count;
    logic             overrun;
    logic [WIDTH-1:0] wdata;

    assign wdata = sel_eng ? eng_wdata_i : host_wdata_i;

    pktbuf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .flush_i   (flush_i),
        .ovr_clr_i (ovr_clr_i),
        .mode_i    (op_mode_e'(mode_i)),
        .host_wr_i (host_wr_i),
        .eng_wr_i  (eng_wr_i),
        .rd_i      (rd_i),
        .op_o      (op),
        .sel_eng_o (sel_eng),
        .count_o   (count),
        .overrun_o (overrun)
    );

    pktbuf_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) mem_i (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op),
        .rd_req_i  (rd_i),
        .wdata_i   (wdata),
        .rd_data_o (rd_data_o)
    );

    pktbuf_status #(.DEPTH(DEPTH)) status_i (
        .clk          (clk),
        .rst          (rst),
        .count_i      (count),
        .thresh_i     (thresh_i),
        .overrun_i    (overrun),
        .cs_n_i       (cs_n_i),
        .flags_o      (flags),
        .host_empty_o (host_empty_o)
    );

    assign empty_o   = flags.empty;
    assign full_o    = flags.full;
    assign overrun_o = flags.overrun;
    assign level_o   = flags.level;

endmodule

// File: tb/pktbuf_top_tb_top.sv
module pktbuf_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fl = 1'b0;
    logic [1:0] mode = 2'd1;
    logic       hwr = 1'b0;
    logic [7:0] hdat = 8'h00;
    logic       ewr = 1'b0;
    logic [7:0] edat = 8'h00;
    logic       rd = 1'b0;
    logic       csn = 1'b1;
    logic       clr = 1'b0;
    logic [5:0] thr = 6'd32;
    logic [7:0] rdata;
    logic       empty, full, ovr, level, hempty;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pktbuf_top dut_i (
        .clk(clk), .rst(rst), .flush_i(fl), .mode_i(mode),
        .host_wr_i(hwr), .host_wdata_i(hdat), .eng_wr_i(ewr), .eng_wdata_i(edat),
        .rd_i(rd), .rd_data_o(rdata), .cs_n_i(csn), .ovr_clr_i(clr), .thresh_i(thr),
        .empty_o(empty), .full_o(full), .overrun_o(ovr), .level_o(level),
        .host_empty_o(hempty)
    );

    // behavioural reference
    byte unsigned q[$];
    bit       ovr_m = 0;
    bit       hemp_m = 1;
    bit       csq_m = 1;
    bit [7:0] rd_m = 0;
    bit       was_empty, was_full, wr_ok;
    bit [7:0] wd;

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); ovr_m = 0; rd_m = 0; hemp_m = 1; csq_m = 1;
        end else begin
            was_empty = (q.size() == 0);
            was_full  = (q.size() == 64);
            if (csq_m && !csn) hemp_m = was_empty;
            csq_m = csn;
            if (fl || clr) begin
                q.delete(); ovr_m = 0;
            end else begin
                wr_ok = ((mode == 2'd0 || mode == 2'd1) && hwr) || (mode == 2'd2 && ewr);
                wd = (mode == 2'd2) ? edat : hdat;
                if (rd) rd_m = was_empty ? 8'h00 : q.pop_front();
                if (wr_ok) begin
                    if (was_full) ovr_m = 1;
                    else q.push_back(wd);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the edge
    always begin
        @(posedge clk);
        #5;
        if (!rst) begin
            chk(empty == (q.size() == 0), "R4 empty", empty, q.size() == 0);
            chk(full == (q.size() == 64), "R4 full", full, q.size() == 64);
            chk(level == (q.size() > thr), "R7 level", level, q.size() > thr);
            chk(ovr == ovr_m, "R5 overrun", ovr, ovr_m);
            chk(hempty == hemp_m, "R11 host_empty", hempty, hemp_m);
            chk(rdata == rd_m, "R2 rd_data", rdata, rd_m);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic hwrite(input logic [7:0] d);
        hwr = 1; hdat = d; step(); hwr = 0;
    endtask

    task automatic hread();
        rd = 1; step(); rd = 0;
    endtask

    task automatic drain(output int n);
        n = 0;
        while (!empty && n < 100) begin
            hread(); n++;
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int n;
        step(); step();
        rst = 0;
        step();
        // R1 reset state
        chk(empty == 1 && hempty == 1 && full == 0 && ovr == 0 && level == 0 && rdata == 0,
            "R1 reset", {empty, hempty, full, ovr, level}, 5'b11000);

        // R2 ordered transfer in transmit mode
        mode = 2'd1;
        for (int i = 0; i < 10; i++) hwrite(8'hA0 + 8'(i));
        for (int i = 0; i < 10; i++) begin
            hread(); chk(rdata == 8'hA0 + 8'(i), "R2 order", rdata, 8'hA0 + i);
        end

        // R3 port selection per mode
        mode = 2'd2; hwr = 1; hdat = 8'h11; step(); hwr = 0;
        chk(empty == 1, "R3 host ignored in receive", empty, 1);
        ewr = 1; edat = 8'h5C; step(); ewr = 0;
        mode = 2'd1; ewr = 1; edat = 8'h77; step(); ewr = 0;
        mode = 2'd3; hwr = 1; ewr = 1; step(); hwr = 0; ewr = 0;
        mode = 2'd0; hwrite(8'h3D);
        drain(n);
        chk(n == 2, "R3 accepted writes", n, 2);
        chk(rdata == 8'h3D, "R3 last byte", rdata, 8'h3D);

        // R8 empty read
        hread(); chk(rdata == 8'h00, "R8 empty read", rdata, 0);
        hwrite(8'h96); hread(); chk(rdata == 8'h96, "R8 pointers held", rdata, 8'h96);

        // R4 R5 fill, overflow with and without read
        mode = 2'd1;
        for (int i = 0; i < 64; i++) hwrite(8'(i));
        chk(full == 1, "R4 full at 64", full, 1);
        hwrite(8'hEE);
        chk(ovr == 1, "R5 overrun set", ovr, 1);
        hwr = 1; hdat = 8'hEF; rd = 1; step(); hwr = 0; rd = 0;
        chk(rdata == 8'h00 && full == 0, "R5 read with dropped write", rdata, 0);
        step(); chk(ovr == 1, "R5 sticky", ovr, 1);

        // R7 threshold boundary
        for (int t = 61; t <= 63; t++) begin
            thr = 6'(t); step();
            chk(level == (t < 63), "R7 boundary", level, t < 63);
        end

        // R6 clear empties, same-cycle read ignored
        clr = 1; rd = 1; step(); clr = 0; rd = 0;
        chk(empty == 1 && ovr == 0 && rdata == 8'h00, "R6 clear", {empty, ovr}, 2'b10);

        // R9 balanced read/write
        thr = 6'd4;
        for (int i = 0; i < 5; i++) hwrite(8'h40 + 8'(i));
        for (int i = 0; i < 6; i++) begin
            hwr = 1; hdat = 8'h50 + 8'(i); rd = 1; step();
        end
        hwr = 0; rd = 0;
        chk(level == 1, "R9 level kept", level, 1);
        drain(n);
        chk(n == 5, "R9 count unchanged", n, 5);

        // R10 flush beats write
        hwrite(8'h01); hwrite(8'h02);
        fl = 1; hwr = 1; hdat = 8'h03; step(); fl = 0; hwr = 0;
        chk(empty == 1, "R10 flush", empty, 1);

        // R11 chip-select sampling
        hwrite(8'h21);
        csn = 0; step();
        chk(hempty == 0, "R11 sampled not empty", hempty, 0);
        hread(); step();
        chk(empty == 1 && hempty == 0, "R11 held during access", hempty, 0);
        csn = 1; step(); csn = 0; step();
        chk(hempty == 1, "R11 resampled", hempty, 1);
        csn = 1; step();

        // mixed traffic compared against the model every clock
        for (int i = 0; i < 4000; i++) begin
            mode = 2'($urandom_range(0, 3));
            hwr  = ($urandom_range(0, 9) < 6);
            ewr  = ($urandom_range(0, 9) < 6);
            hdat = 8'($urandom);
            edat = 8'($urandom);
            rd   = ($urandom_range(0, 9) < 4);
            csn  = ($urandom_range(0, 3) != 0);
            clr  = ($urandom_range(0, 199) == 0);
            fl   = ($urandom_range(0, 299) == 0);
            if ($urandom_range(0, 49) == 0) thr = 6'($urandom);
            step();
        end
        hwr = 0; ewr = 0; rd = 0; clr = 0; fl = 0; csn = 1;
        step(); step();
        summary();
    end

endmodule